// File: doc/BRIEF.md
# NMI Flag Controller with Watchdog

This block gathers non-maskable interrupt requests from several event sources and from a level-sensitive missing-clock status line. Each source has its own sticky pending flag. A summary bit reports that at least one request is active, and it drives the NMI line to the CPU. Handler software reads the flags through a small register port and clears each one by writing 1 to its bit in a clear register.

A watchdog counter runs while any individual flag is pending. If software does not clear every pending flag before the counter reaches the programmed period, the block raises a one-cycle device reset request. The summary bit cannot be lost while work remains: if software clears it while an individual flag is still pending, it comes back on the next cycle. The missing-clock flag follows its input level, also during reset. So a clock failure that outlasts a watchdog reset raises a fresh NMI as soon as reset ends.

Register map (2-bit address): 0 = status (read), 1 = clear (write), 2 = timeout period (read/write), 3 = watchdog count (read). Status layout: bit 0 is the summary bit, bits 1..NUM_EVT are the event flags in input order, and bit NUM_EVT+1 is the missing-clock flag. The clear register uses the same bit positions.

Top module: `nmi_guard`

## Requirements
- R1: A high on `evt_i[i]` at a clock edge sets flag `i`, which reads as status bit `i+1` from the next cycle and stays set until it is cleared.
- R2: While `mclk_fail_i` is high, the missing-clock flag (status bit NUM_EVT+1) is set at every edge. During reset this flag and the summary bit load the level of `mclk_fail_i`, so a persistent clock failure shows as a pending NMI on the first cycle after reset.
- R3: Writing the clear register (address 1) clears each flag whose bit is 1. Bits written 0 have no effect. A set request in the same cycle as its clear wins, and the flag stays set.
- R4: The summary bit (status bit 0) is set in the cycle after any flag is set. If it is cleared (clear bit 0) while an individual flag is still pending, it reads 0 for one cycle and is 1 again in the cycle after that. It stays 0 only when it is cleared with no flag pending.
- R5: `nmi_o` equals the summary bit at all times. No mask exists.
- R6: The watchdog count (address 3) is 0 in any cycle that follows a cycle with no flag pending. It rises by 1 per cycle while a flag is pending and no expiry occurs.
- R7: Expiry happens in a cycle where a flag is pending and count >= period. The next cycle has `wd_rst_o` high for exactly one cycle and the count back at 0. A flag that first shows as pending in cycle k gives `wd_rst_o` in cycle k+period+1.
- R8: The period register (address 2) is 16 bits wide. It reads 0xFFFF after reset and returns the last value written.
- R9: After reset, all event flags are 0, the count is 0 and `wd_rst_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | NUM_EVT | Per-source NMI set requests |
| mclk_fail_i | input | 1 | Missing-clock status level |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for `reg_addr` |
| nmi_o | output | 1 | NMI to the CPU (summary bit) |
| wd_rst_o | output | 1 | One-cycle device reset request |

## Verification
The checker tests the following on every cycle: set requests reach their flags, the summary bit returns when it has been cleared with flags still pending, the counter steps up or is held at zero, and the reset request lasts one cycle. Other behaviour only shows up in the bench's scenarios. These are the exact expiry latency for a given period, same-cycle set-versus-clear priority, zero-valued clear bits having no effect, and a missing-clock level that is still high across a watchdog-triggered reset raising an NMI at once. Random traffic compared against a cycle model covers nested requests arriving while earlier ones are being cleared.

// File: rtl/nmi_guard_pkg.sv
// Shared register address map for the NMI flag controller.
package nmi_guard_pkg;
    typedef enum logic [1:0] {
        REG_STATUS = 2'd0,
        REG_CLEAR  = 2'd1,
        REG_PERIOD = 2'd2,
        REG_COUNT  = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/nmi_flag_bank.sv
// Sticky per-source pending flags plus the summary bit.
// Assumes: set_i bit NF-1 is the missing-clock level; clr_i[0] clears the
// summary and clr_i[i+1] clears flag i; a set wins over a clear.
module nmi_flag_bank #(
    parameter int NF = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set_i,
    input  logic          mclk_lvl_i,
    input  logic [NF:0]   clr_i,
    output logic [NF-1:0] flag_o,
    output logic          sum_o
);
    logic [NF-1:0] flag_q;
    logic          sum_q;

    genvar gi;
    generate
        for (gi = 0; gi < NF; gi++) begin : g_flag
            // Purpose: hold one pending flag, reset value depends on its source.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    flag_q[gi] <= (gi == NF - 1) ? mclk_lvl_i : 1'b0;
                end else begin
                    flag_q[gi] <= set_i[gi] | (flag_q[gi] & ~clr_i[gi+1]);
                end
            end
        end
    endgenerate

    // Purpose: summary bit, set by any request and re-armed by pending flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= mclk_lvl_i;
        end else begin
            sum_q <= (|set_i) | (~clr_i[0] & (sum_q | (|flag_q)));
        end
    end

    assign flag_o = flag_q;
    assign sum_o  = sum_q;
endmodule

// File: rtl/nmi_watchdog.sv
// Counter that runs while any flag is pending and emits a reset pulse on expiry.
// Assumes: period may be changed at any time; the >= compare keeps it bounded.
module nmi_watchdog #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pend_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wd_rst_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             wd_q;
    logic             expire;

    assign expire = pend_i && (cnt_q >= period_i);

    // Purpose: advance, restart or hold the timeout counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!pend_i || expire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Purpose: register the one-cycle reset request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wd_q <= 1'b0;
        end else begin
            wd_q <= expire;
        end
    end

    assign cnt_o    = cnt_q;
    assign wd_rst_o = wd_q;
endmodule

// File: rtl/nmi_regport.sv
// Register decode: clear strobes, period register and read multiplexer.
// Assumes: NF + 1 <= CNT_W so the status word fits in the data bus.
module nmi_regport
    import nmi_guard_pkg::*;
#(
    parameter int NF    = 5,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       addr_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic [NF-1:0]    flag_i,
    input  logic             sum_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [NF:0]      clr_o,
    output logic [CNT_W-1:0] period_o,
    output logic [CNT_W-1:0] rdata_o
);
    localparam int PAD = CNT_W - NF - 1;

    logic [CNT_W-1:0] period_q;
    reg_addr_e        sel;

    assign sel   = reg_addr_e'(addr_i);
    assign clr_o = (wr_i && sel == REG_CLEAR) ? wdata_i[NF:0] : '0;

    // Purpose: hold the timeout period, maximum after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '1;
        end else if (wr_i && sel == REG_PERIOD) begin
            period_q <= wdata_i;
        end
    end

    // Purpose: select the register addressed for reading.
    always_comb begin
        case (sel)
            REG_STATUS: rdata_o = {{PAD{1'b0}}, flag_i, sum_i};
            REG_PERIOD: rdata_o = period_q;
            REG_COUNT:  rdata_o = cnt_i;
            default:    rdata_o = '0;
        endcase
    end

    assign period_o = period_q;
endmodule

// File: rtl/nmi_guard.sv
// Top: NMI flag controller with watchdog reset request.
// Assumes: evt_i and mclk_fail_i are synchronous to clk; NUM_EVT <= CNT_W - 2.
module nmi_guard #(
    parameter int NUM_EVT = 4,
    parameter int CNT_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               mclk_fail_i,
    input  logic [1:0]         reg_addr,
    input  logic               reg_wr,
    input  logic [CNT_W-1:0]   reg_wdata,
    output logic [CNT_W-1:0]   reg_rdata,
    output logic               nmi_o,
    output logic               wd_rst_o
);
    localparam int NF = NUM_EVT + 1;

    logic [NF-1:0]    set_vec;
    logic [NF-1:0]    flag_q;
    logic             sum_q;
    logic [NF:0]      clr_vec;
    logic             clr_sum;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] period_q;

    assign set_vec = {mclk_fail_i, evt_i};
    assign clr_sum = clr_vec[0];

    nmi_flag_bank #(.NF(NF)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (set_vec),
        .mclk_lvl_i (mclk_fail_i),
        .clr_i      (clr_vec),
        .flag_o     (flag_q),
        .sum_o      (sum_q)
    );

    nmi_watchdog #(.CNT_W(CNT_W)) u_wd (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_i   (|flag_q),
        .period_i (period_q),
        .cnt_o    (cnt_q),
        .wd_rst_o (wd_rst_o)
    );

    nmi_regport #(.NF(NF), .CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (reg_addr),
        .wr_i     (reg_wr),
        .wdata_i  (reg_wdata),
        .flag_i   (flag_q),
        .sum_i    (sum_q),
        .cnt_i    (cnt_q),
        .clr_o    (clr_vec),
        .period_o (period_q),
        .rdata_o  (reg_rdata)
    );

    assign nmi_o = sum_q;
endmodule

// File: rtl/nmi_guard_chk.sv
// Cycle checker for nmi_guard, bound to every instance.
module nmi_guard_chk #(
    parameter int NUM_EVT = 4,
    parameter int CNT_W   = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_EVT-1:0] evt_i,
    input logic               mclk_fail_i,
    input logic [NUM_EVT:0]   flag_q,
    input logic               sum_q,
    input logic               clr_sum,
    input logic [CNT_W-1:0]   cnt_q,
    input logic [CNT_W-1:0]   period_q,
    input logic               wd_rst_o
);
    logic armed;

    // Purpose: enable past-looking checks one cycle after reset ends.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    p_set_reaches_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> ((flag_q & $past({mclk_fail_i, evt_i})) == $past({mclk_fail_i, evt_i})));

    p_summary_rearms_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && (flag_q != '0) && !clr_sum) |=> sum_q);

    p_count_steps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && (flag_q != '0) && (cnt_q < period_q)) |=> (cnt_q == $past(cnt_q) + 1'b1));

    p_count_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && (flag_q == '0)) |=> (cnt_q == '0));

    p_reset_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && wd_rst_o && (period_q != '0)) |=> !wd_rst_o);
endmodule

bind nmi_guard nmi_guard_chk #(.NUM_EVT(NUM_EVT), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt_i),
    .mclk_fail_i (mclk_fail_i),
    .flag_q      (flag_q),
    .sum_q       (sum_q),
    .clr_sum     (clr_sum),
    .cnt_q       (cnt_q),
    .period_q    (period_q),
    .wd_rst_o    (wd_rst_o)
);

// File: tb/nmi_guard_test.sv
module nmi_guard_test;
    localparam int NE = 4;
    localparam int NF = NE + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NE-1:0] evt_i = '0;
    logic          mclk_fail_i = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;
    logic          nmi_o;
    logic          wd_rst_o;

    int total = 0;
    int bad   = 0;

    // model state
    logic [NF-1:0] m_flag;
    logic          m_sum;
    logic [15:0]   m_cnt;
    logic [15:0]   m_per;
    logic          m_wd;

    nmi_guard #(.NUM_EVT(NE), .CNT_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .mclk_fail_i(mclk_fail_i),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .nmi_o(nmi_o), .wd_rst_o(wd_rst_o)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] m_read(input logic [1:0] a);
        case (a)
            2'd0: m_read = {{(16-NF-1){1'b0}}, m_flag, m_sum};
            2'd2: m_read = m_per;
            2'd3: m_read = m_cnt;
            default: m_read = 16'h0;
        endcase
    endfunction

    task automatic cyc(input logic [NE-1:0] e, input logic m, input logic w,
                       input logic [1:0] a, input logic [15:0] d);
        logic [NF:0]   clr;
        logic [NF-1:0] setv;
        logic [NF-1:0] nflag;
        logic          nsum, pend, expv;
        logic [15:0]   ncnt, nper;
        @(negedge clk);
        evt_i = e; mclk_fail_i = m; reg_wr = w; reg_addr = a; reg_wdata = d;
        #1;
        if (!w) chk(a == 2'd0 ? "R1 status" : a == 2'd2 ? "R8 period" :
                    a == 2'd3 ? "R6 count" : "R3 clear-read", reg_rdata, m_read(a));
        clr   = (w && a == 2'd1) ? d[NF:0] : '0;
        setv  = {m, e};
        nflag = setv | (m_flag & ~clr[NF:1]);
        nsum  = (|setv) | (~clr[0] & (m_sum | (|m_flag)));
        pend  = |m_flag;
        expv  = pend && (m_cnt >= m_per);
        ncnt  = (!pend || expv) ? 16'h0 : m_cnt + 16'h1;
        nper  = (w && a == 2'd2) ? d : m_per;
        @(posedge clk);
        #1;
        m_flag = nflag; m_sum = nsum; m_cnt = ncnt; m_per = nper; m_wd = expv;
        chk("R5 nmi", nmi_o, m_sum);
        chk("R7 wdrst", wd_rst_o, m_wd);
    endtask

    task automatic do_reset(input logic m);
        @(negedge clk);
        rst_n = 1'b0; mclk_fail_i = m; evt_i = '0; reg_wr = 1'b0;
        @(posedge clk);
        #1;
        m_flag = '0; m_flag[NF-1] = m; m_sum = m; m_cnt = 0; m_per = 16'hFFFF; m_wd = 0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc('0, 1'b0, 1'b0, 2'd0, 16'h0);
    endtask

    initial begin
        #1500000;
        bad++; total++;
        $display("FAIL watchdog timeout");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed;
        int lat;
        seed = 32'h5eed1;
        void'($urandom(seed));

        // R9 reset state
        do_reset(1'b0);
        #1;
        reg_addr = 2'd0; #1; chk("R9 status", reg_rdata, 16'h0);
        reg_addr = 2'd3; #1; chk("R9 count", reg_rdata, 16'h0);
        reg_addr = 2'd2; #1; chk("R8 reset period", reg_rdata, 16'hFFFF);
        chk("R9 wdrst", wd_rst_o, 1'b0);

        // R3 clear semantics
        cyc(4'b0010, 0, 0, 2'd0, 0);
        cyc('0, 0, 1, 2'd1, 16'h0000);          // zero bits: no effect
        reg_addr = 2'd0; #1; chk("R3 zero write", reg_rdata, 16'h0005);
        cyc(4'b0010, 0, 1, 2'd1, 16'h0004);     // set wins over clear
        reg_addr = 2'd0; #1; chk("R3 set beats clear", reg_rdata, 16'h0005);
        cyc('0, 0, 1, 2'd1, 16'h0004);
        reg_addr = 2'd0; #1; chk("R3 cleared", reg_rdata, 16'h0001);

        // R4 nested: two flags, clear summary and first flag
        cyc(4'b0001, 0, 0, 2'd0, 0);
        cyc(4'b1000, 0, 0, 2'd0, 0);
        cyc('0, 0, 1, 2'd1, 16'h0003);          // clear summary + flag0
        chk("R4 summary dropped", nmi_o, 1'b0);
        cyc('0, 0, 0, 2'd0, 0);
        chk("R4 summary reasserts", nmi_o, 1'b1);
        cyc('0, 0, 1, 2'd1, 16'h0011);          // clear summary + flag3
        cyc('0, 0, 0, 2'd0, 0);
        chk("R4 summary stays clear", nmi_o, 1'b0);
        idle(2);

        // R7 expiry latency with period 5
        cyc('0, 0, 1, 2'd2, 16'd5);
        cyc(4'b0100, 0, 0, 2'd0, 0);
        lat = 0;
        for (int i = 0; i < 20 && !wd_rst_o; i++) begin
            cyc('0, 0, 0, 2'd3, 0);
            lat++;
        end
        chk("R7 latency", lat, 6);
        cyc('0, 0, 0, 2'd3, 0);
        chk("R7 one-cycle pulse", wd_rst_o, 1'b0);

        // R2 missing clock persists across a watchdog reset
        cyc('0, 1, 0, 2'd0, 0);
        do_reset(1'b1);
        #1;
        chk("R2 nmi after reset", nmi_o, 1'b1);
        reg_addr = 2'd0; #1; chk("R2 flag after reset", reg_rdata, 16'h0021);
        cyc('0, 1, 1, 2'd1, 16'h0021);
        reg_addr = 2'd0; #1; chk("R2 level re-sets", reg_rdata, 16'h0021);
        cyc('0, 0, 1, 2'd1, 16'h0021);
        idle(2);

        // random traffic against the model
        cyc('0, 0, 1, 2'd2, 16'd20);
        for (int i = 0; i < 4000; i++) begin
            logic [NE-1:0] e;
            logic          m, w;
            logic [1:0]    a;
            logic [15:0]   d;
            for (int b = 0; b < NE; b++) e[b] = ($urandom % 16) == 0;
            m = ($urandom % 64) == 0;
            w = ($urandom % 3) == 0;
            a = 2'($urandom % 4);
            if (w && a == 2'd2) d = 16'($urandom % 40);
            else d = 16'($urandom);
            cyc(e, m, w, a, d);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule